// File: doc/BRIEF.md
# Shared-Bus Ownership Controller with Parking and Indivisible Lock

This block decides when a processor may drive a bus that it shares with other masters. When the core presents a transfer, the block raises an active-low bus request towards an external arbiter. It then waits for two things in the same clock: the grant, and a released shared bus-busy line. Only then does it pull bus-busy low and start accepting core transfers. Once it owns the bus it stays on it after the last transfer, which is called parking, for as long as the arbiter keeps the grant. New transfers are then taken with no new arbitration.

Bus-busy is an open-drain style line, so it is split into input, output value and output enable. To give the line back, the block drives it high for exactly one clock and then stops driving it, leaving it to the external pull-up. A bus-lock output, active low, covers an indivisible read-modify-write pair from the read beat through the write beat. A lock-hold control input can force the lock on at any time.

The core side is a valid/ready interface. `xfer_valid` must stay high, with `xfer_rmw` stable, until the cycle in which `xfer_ready` is high. A beat is taken on the rising edge where both are high, and that is the only back-pressure there is. An indivisible pair is two accepted beats: the first has `xfer_rmw` = 1 (the read), and the next accepted beat is the write, whatever its `xfer_rmw` value.

Top module: `bus_owner_ctrl`

## Requirements
- R1: While `rst_n` is low, `bus_req_n`, `busy_out_n` and `bus_lock_n` are high, and `busy_oe` and `xfer_ready` are low, whatever the inputs are.
- R2: A valid transfer in the idle state drives `bus_req_n` low from the next cycle. `busy_oe` goes high with `busy_out_n` low only in the cycle after a clock edge at which `arb_grant_n` is low and `busy_in_n` is high.
- R3: With parking enabled (the default), an owner whose grant is held keeps `busy_oe` high and `busy_out_n` low through idle cycles. A transfer presented while parked is accepted in the same cycle.
- R4: `xfer_ready` is high only while the block drives `busy_out_n` low with `busy_oe` high.
- R5: When the grant is removed, no transfer is valid and no indivisible pair is open, the next cycle has `busy_oe` high with `busy_out_n` high and `bus_req_n` high. The cycle after that has `busy_oe` low.
- R6: `bus_lock_n` is low in the read-beat cycle of an indivisible pair, in every cycle between the two beats, and in the write-beat cycle. It is high again in the cycle after the write beat unless lock-hold is set.
- R7: While an indivisible pair is open, removing the grant does not release the bus.
- R8: When `lock_hold` is sampled high at a clock edge, `bus_lock_n` is low for the following cycle, whatever the transfer type.
- R9: Ordinary beats and idle cycles leave `bus_lock_n` high when no pair is open and lock-hold is clear.
- R10: While `busy_in_n` is low, the block does not take the bus, even when it holds the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-synchronous clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_valid | input | 1 | Core transfer valid |
| xfer_rmw | input | 1 | Marks the read beat that opens an indivisible pair |
| xfer_ready | output | 1 | Transfer accepted this cycle |
| lock_hold | input | 1 | Control bit that forces the lock on |
| arb_grant_n | input | 1 | Arbiter grant, active low |
| busy_in_n | input | 1 | Sensed level of the shared bus-busy line |
| bus_req_n | output | 1 | Bus request to the arbiter, active low |
| busy_out_n | output | 1 | Value driven on bus-busy |
| busy_oe | output | 1 | Output enable for bus-busy |
| bus_lock_n | output | 1 | Bus lock, active low |

## Verification
The assertions assume the core obeys the valid/ready rule: `xfer_valid` and `xfer_rmw` stay stable until acceptance. They also assume that `busy_in_n` reflects other masters only while this block is not driving the line. The bench changes inputs only on falling edges. It holds valid until ready, and while the block owns the bus it keeps `busy_in_n` high, as the pulled-up line would be. Takeover is held off by keeping `busy_in_n` low only before the block acquires the bus.

// File: rtl/bown_pkg.sv
package bown_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HELD = 2'd2,
    ST_DROP = 2'd3
  } own_state_e;
endpackage

// File: rtl/bown_fsm.sv
module bown_fsm
  import bown_pkg::*;
#(
  parameter bit PARK_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_valid,
  input  logic rmw_open,
  input  logic arb_grant_n,
  input  logic busy_in_n,
  output logic bus_req_n,
  output logic busy_out_n,
  output logic busy_oe,
  output logic owner_ready
);
  own_state_e state_q, state_d;
  logic       give_up;

  generate
    if (PARK_EN) begin : g_park
      // stay parked until the arbiter withdraws the grant
      assign give_up = arb_grant_n && !xfer_valid && !rmw_open;
    end else begin : g_noprk
      // hand the bus back as soon as the work is done
      assign give_up = !xfer_valid && !rmw_open;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (xfer_valid) state_d = ST_WAIT;
      ST_WAIT: if (!arb_grant_n && busy_in_n) state_d = ST_HELD;
      ST_HELD: if (give_up) state_d = ST_DROP;
      ST_DROP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy_oe     = (state_q == ST_HELD) || (state_q == ST_DROP);
  assign busy_out_n  = (state_q != ST_HELD);
  assign owner_ready = (state_q == ST_HELD);
  assign bus_req_n   = !((state_q == ST_WAIT) ||
                         ((state_q == ST_HELD) && (xfer_valid || rmw_open)));
endmodule

// File: rtl/bown_lock.sv
module bown_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic xfer_rmw,
  input  logic lock_hold,
  output logic rmw_open,
  output logic bus_lock_n
);
  logic open_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= lock_hold;
      if (accept) begin
        // second beat of a pair closes it, a marked first beat opens one
        open_q <= open_q ? 1'b0 : xfer_rmw;
      end
    end
  end

  assign rmw_open   = open_q;
  assign bus_lock_n = !(hold_q || open_q || (accept && xfer_rmw));
endmodule

// File: rtl/bus_owner_ctrl.sv
module bus_owner_ctrl #(
  parameter bit PARK_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_valid,
  input  logic xfer_rmw,
  output logic xfer_ready,
  input  logic lock_hold,
  input  logic arb_grant_n,
  input  logic busy_in_n,
  output logic bus_req_n,
  output logic busy_out_n,
  output logic busy_oe,
  output logic bus_lock_n
);
  logic rmw_open;
  logic owner_ready;
  logic accept;

  assign xfer_ready = owner_ready;
  assign accept     = xfer_valid && owner_ready;

  bown_fsm #(.PARK_EN(PARK_EN)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_valid  (xfer_valid),
    .rmw_open    (rmw_open),
    .arb_grant_n (arb_grant_n),
    .busy_in_n   (busy_in_n),
    .bus_req_n   (bus_req_n),
    .busy_out_n  (busy_out_n),
    .busy_oe     (busy_oe),
    .owner_ready (owner_ready)
  );

  bown_lock u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .xfer_rmw   (xfer_rmw),
    .lock_hold  (lock_hold),
    .rmw_open   (rmw_open),
    .bus_lock_n (bus_lock_n)
  );
endmodule

// File: rtl/bown_chk.sv
module bown_chk #(
  parameter bit PARK_EN = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic xfer_valid,
  input logic xfer_rmw,
  input logic xfer_ready,
  input logic lock_hold,
  input logic arb_grant_n,
  input logic busy_in_n,
  input logic bus_req_n,
  input logic busy_out_n,
  input logic busy_oe,
  input logic bus_lock_n
);
  // R2 / R10: driving starts only after a granted, released line
  p_take_after_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_oe) |-> ($past(busy_in_n) && !$past(arb_grant_n) && !busy_out_n));

  // R4: acknowledge only as the active owner
  p_ack_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ready |-> (busy_oe && !busy_out_n));

  // R5: the high-drive phase lasts one cycle, then the line is released
  p_pullup_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_oe && busy_out_n) |=> !busy_oe);

  p_pullup_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_oe) |-> $past(busy_out_n));

  // R6: the read beat of a pair is locked
  p_lock_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready && xfer_rmw) |-> !bus_lock_n);

  // R8: lock-hold forces the lock on the next cycle
  p_hold_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock_hold) && $past(rst_n)) |-> !bus_lock_n);

  generate
    if (PARK_EN) begin : g_park_chk
      // R3: with the grant held, the owner stays parked
      p_park_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_oe && !busy_out_n && !arb_grant_n) |=> (busy_oe && !busy_out_n));
    end
  endgenerate
endmodule

bind bus_owner_ctrl bown_chk #(.PARK_EN(PARK_EN)) u_bown_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xfer_valid  (xfer_valid),
  .xfer_rmw    (xfer_rmw),
  .xfer_ready  (xfer_ready),
  .lock_hold   (lock_hold),
  .arb_grant_n (arb_grant_n),
  .busy_in_n   (busy_in_n),
  .bus_req_n   (bus_req_n),
  .busy_out_n  (busy_out_n),
  .busy_oe     (busy_oe),
  .bus_lock_n  (bus_lock_n)
);

// File: tb/test_bus_owner_ctrl.sv
module test_bus_owner_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_valid = 1'b0;
  logic xfer_rmw = 1'b0;
  logic lock_hold = 1'b0;
  logic arb_grant_n = 1'b1;
  logic busy_in_n = 1'b1;
  logic xfer_ready, bus_req_n, busy_out_n, busy_oe, bus_lock_n;

  int checks = 0;
  int errors = 0;
  bit hold_m = 1'b0;  // bench view of the sampled lock-hold bit
  bit pend_m = 1'b0;  // bench view of an open indivisible pair
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bus_owner_ctrl i_bus_owner_ctrl (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_rmw(xfer_rmw),
    .xfer_ready(xfer_ready), .lock_hold(lock_hold), .arb_grant_n(arb_grant_n),
    .busy_in_n(busy_in_n), .bus_req_n(bus_req_n), .busy_out_n(busy_out_n),
    .busy_oe(busy_oe), .bus_lock_n(bus_lock_n)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic exp_lock(input string req);
    check(req, "bus_lock_n", bus_lock_n, !(hold_m || pend_m));
  endtask

  // take the bus with one ordinary beat, holding the line busy first (R10)
  task automatic acquire();
    @(negedge clk);
    xfer_valid = 1'b1; xfer_rmw = 1'b0; arb_grant_n = 1'b1; busy_in_n = 1'b0;
    @(negedge clk);
    check("R2", "bus_req_n wait", bus_req_n, 1'b0);
    check("R4", "xfer_ready wait", xfer_ready, 1'b0);
    arb_grant_n = 1'b0;
    @(negedge clk);
    check("R10", "busy_oe with line busy", busy_oe, 1'b0);
    busy_in_n = 1'b1;
    @(negedge clk);
    check("R2", "busy_oe after take", busy_oe, 1'b1);
    check("R2", "busy_out_n after take", busy_out_n, 1'b0);
    check("R4", "xfer_ready owner", xfer_ready, 1'b1);
    exp_lock("R9");
    @(negedge clk);
    xfer_valid = 1'b0;
    #1 exp_lock("R9");
  endtask

  task automatic beat(input bit rmw);
    @(negedge clk);
    xfer_valid = 1'b1; xfer_rmw = rmw;
    #1;
    check("R3", "accept while parked", xfer_ready, 1'b1);
    check("R6", "lock during beat", bus_lock_n, !(hold_m || pend_m || rmw));
    if (pend_m) pend_m = 1'b0; else pend_m = rmw;
    @(negedge clk);
    xfer_valid = 1'b0; xfer_rmw = 1'b0;
    #1;
    exp_lock(pend_m ? "R6" : "R9");
    check("R3", "still driving busy", busy_out_n, 1'b0);
  endtask

  task automatic gap();
    if (pend_m) arb_grant_n = 1'b1;
    @(negedge clk);
    check(pend_m ? "R7" : "R3", "owner kept", busy_oe && !busy_out_n, 1'b1);
    exp_lock(pend_m ? "R6" : "R9");
    arb_grant_n = 1'b0;
  endtask

  task automatic release_bus();
    arb_grant_n = 1'b1;
    @(negedge clk);
    check("R5", "pull-up phase oe", busy_oe, 1'b1);
    check("R5", "pull-up phase value", busy_out_n, 1'b1);
    check("R5", "request dropped", bus_req_n, 1'b1);
    @(negedge clk);
    check("R5", "line released", busy_oe, 1'b0);
  endtask

  initial begin
    xfer_valid = 1'b1; lock_hold = 1'b1; arb_grant_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "bus_req_n reset", bus_req_n, 1'b1);
    check("R1", "busy_out_n reset", busy_out_n, 1'b1);
    check("R1", "busy_oe reset", busy_oe, 1'b0);
    check("R1", "bus_lock_n reset", bus_lock_n, 1'b1);
    check("R1", "xfer_ready reset", xfer_ready, 1'b0);
    xfer_valid = 1'b0; lock_hold = 1'b0; arb_grant_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int h = 0; h < 2; h++) begin
      @(negedge clk);
      lock_hold = h[0];
      @(negedge clk);
      hold_m = h[0];
      exp_lock("R8");
      // four slots; a set bit is an indivisible pair, a clear bit an ordinary beat
      for (int pat = 0; pat < 16; pat++) begin
        acquire();
        for (int s = 0; s < 4; s++) begin
          if (pat[s]) begin
            beat(1'b1);
            gap();
            gap();
            beat(1'b0);
          end else begin
            beat(1'b0);
          end
          gap();
        end
        release_bus();
        exp_lock(h[0] ? "R8" : "R9");
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule